// File: doc/BRIEF.md
# Zero-Crossing Quality Detector

This block rates the received signal by checking each zero crossing the clock-recovery loop reports. The loop gives a crossing strobe together with a signed timing error, measured in sub-bit ticks with 64 ticks per bit period. The block calls a crossing good when the error magnitude falls within a tolerance window. Otherwise the crossing is bad.

The main output is a single quality bit. A bad crossing pulls it low straight away. It goes high again only after an unbroken run of good crossings. Downstream logic can average this bit over time to estimate signal-to-noise ratio. The bit changes only when a crossing arrives. The block has no input from the clock-recovery loop's hold state, so it keeps working whenever crossings keep coming. Receive power-save forces the output low.

A test tally, enabled by parameter, counts good and bad crossings over a window of bit strobes. At the end of each window it presents saturating totals.

Top module: `zcq_detector`

## Requirements
- R1: A crossing is good when |xing_err| <= TOL ticks (default 8, i.e. 1/8 of a 64-tick bit). xing_err is ERR_W-bit two's complement (default 7 bits), and -64 counts as magnitude 64.
- R2: A bad crossing, seen with xing_vld high and psave low, makes quality_o 0 from the next clock edge on and restarts the good run.
- R3: quality_o becomes 1 on the clock edge that samples the RUN_LEN-th consecutive good crossing (default 4). It stays 1 while later crossings are good.
- R4: In a cycle with no crossing strobe and psave low, quality_o keeps its value.
- R5: While psave is high, quality_o is 0 after the next edge, crossings are ignored and the run count clears. After release, a full run of RUN_LEN good crossings is needed again.
- R6: After synchronous reset, quality_o, good_cnt_o and bad_cnt_o are all 0.
- R7: The tally counts good and bad crossings over WIN bit strobes (default 64). On the edge that samples the WIN-th strobe, good_cnt_o and bad_cnt_o load the window totals, including any crossing in that same cycle. The accumulators then restart from 0. The outputs hold between window ends.
- R8: The tally accumulators and outputs saturate at 2^CNT_W-1 (default 255).
- R9: While psave is high, the tally accumulators, the bit-strobe count and both tally outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psave | input | 1 | Receive power-save |
| xing_vld | input | 1 | Crossing strobe, one cycle per crossing |
| xing_err | input | ERR_W | Signed timing error of the crossing, in ticks |
| bit_stb | input | 1 | One-cycle strobe per received bit period |
| quality_o | output | 1 | Run-based quality flag |
| good_cnt_o | output | CNT_W | Good crossings in the last complete window |
| bad_cnt_o | output | CNT_W | Bad crossings in the last complete window |

## Verification
The assertions check the per-cycle rules on every cycle: a bad crossing forces the flag low, power-save forces it low, the flag holds when no crossing arrives, a rise always follows a good crossing, and a saturated accumulator stays saturated. Other behaviour depends on history, and only the bench scenarios can show it. This covers the exact count of good crossings before the flag rises, the tolerance boundary at ±8 and ±9 and at -64, the window totals including a crossing that lands on the closing strobe, saturation under dense crossings, and the full run needed after power-save is released.

// File: rtl/zcq_pkg.sv
package zcq_pkg;
  // Magnitude of a signed error, widened by one bit so the most negative code is exact.
  function automatic logic [15:0] err_mag(input logic signed [15:0] e);
    logic signed [16:0] w;
    w = {e[15], e};
    if (w < 0) w = -w;
    return w[15:0];
  endfunction
endpackage

// File: rtl/zcq_classify.sv
module zcq_classify #(
  parameter int ERR_W = 7,
  parameter int TOL   = 8
) (
  input  logic signed [ERR_W-1:0] err,
  output logic                    good
);
  import zcq_pkg::*;
  localparam int PAD = 16 - ERR_W;

  logic signed [15:0] err_ext;
  logic        [15:0] mag;

  always_comb begin
    err_ext = {{PAD{err[ERR_W-1]}}, err};
    mag     = err_mag(err_ext);
    good    = (mag <= 16'(TOL));
  end
endmodule

// File: rtl/zcq_run_flag.sv
module zcq_run_flag #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic psave,
  input  logic xing_vld,
  input  logic good,
  output logic qual
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nx;

  always_comb begin
    if (run_q >= RUN_W'(RUN_LEN)) run_nx = RUN_W'(RUN_LEN);
    else                          run_nx = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || psave) begin
      run_q <= '0;
      qual  <= 1'b0;
    end else if (xing_vld) begin
      if (good) begin
        run_q <= run_nx;
        qual  <= (run_nx >= RUN_W'(RUN_LEN));
      end else begin
        run_q <= '0;
        qual  <= 1'b0;
      end
    end
  end

  p_bad_drops_r2: assert property (@(posedge clk) disable iff (rst)
    (xing_vld && !good && !psave) |=> !qual);
  p_psave_low_r5: assert property (@(posedge clk) disable iff (rst)
    psave |=> !qual);
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!xing_vld && !psave) |=> $stable(qual));
  p_rise_on_good_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(qual) |-> ($past(xing_vld) && $past(good)));
endmodule

// File: rtl/zcq_tally.sv
module zcq_tally #(
  parameter int CNT_W = 8,
  parameter int WIN   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             psave,
  input  logic             xing_vld,
  input  logic             good,
  input  logic             bit_stb,
  output logic [CNT_W-1:0] good_cnt,
  output logic [CNT_W-1:0] bad_cnt
);
  localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [WIN_W-1:0] bits_q;
  logic [CNT_W-1:0] acc_g, acc_b, g_nx, b_nx;
  logic             close_w;

  always_comb begin
    g_nx = acc_g;
    b_nx = acc_b;
    if (xing_vld && good  && acc_g != CMAX) g_nx = acc_g + 1'b1;
    if (xing_vld && !good && acc_b != CMAX) b_nx = acc_b + 1'b1;
    close_w = bit_stb && (bits_q == WIN_W'(WIN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || psave) begin
      bits_q   <= '0;
      acc_g    <= '0;
      acc_b    <= '0;
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (close_w) begin
      bits_q   <= '0;
      acc_g    <= '0;
      acc_b    <= '0;
      good_cnt <= g_nx;
      bad_cnt  <= b_nx;
    end else begin
      acc_g <= g_nx;
      acc_b <= b_nx;
      if (bit_stb) bits_q <= bits_q + 1'b1;
    end
  end

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_g == CMAX && !psave && !close_w) |=> (acc_g == CMAX));
  p_psave_clear_r9: assert property (@(posedge clk) disable iff (rst)
    psave |=> (good_cnt == '0 && bad_cnt == '0));
  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!close_w && !psave) |=> ($stable(good_cnt) && $stable(bad_cnt)));
endmodule

// File: rtl/zcq_detector.sv
module zcq_detector #(
  parameter int ERR_W    = 7,
  parameter int TOL      = 8,
  parameter int RUN_LEN  = 4,
  parameter int CNT_W    = 8,
  parameter int WIN      = 64,
  parameter bit TALLY_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    psave,
  input  logic                    xing_vld,
  input  logic signed [ERR_W-1:0] xing_err,
  input  logic                    bit_stb,
  output logic                    quality_o,
  output logic [CNT_W-1:0]        good_cnt_o,
  output logic [CNT_W-1:0]        bad_cnt_o
);
  logic good_w;

  zcq_classify #(.ERR_W(ERR_W), .TOL(TOL)) u_cls (
    .err (xing_err),
    .good(good_w)
  );

  zcq_run_flag #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst     (rst),
    .psave   (psave),
    .xing_vld(xing_vld),
    .good    (good_w),
    .qual    (quality_o)
  );

  generate
    if (TALLY_EN) begin : g_tally
      zcq_tally #(.CNT_W(CNT_W), .WIN(WIN)) u_tly (
        .clk     (clk),
        .rst     (rst),
        .psave   (psave),
        .xing_vld(xing_vld),
        .good    (good_w),
        .bit_stb (bit_stb),
        .good_cnt(good_cnt_o),
        .bad_cnt (bad_cnt_o)
      );
    end else begin : g_no_tally
      logic unused_w;
      assign unused_w   = bit_stb;
      assign good_cnt_o = '0;
      assign bad_cnt_o  = '0;
    end
  endgenerate
endmodule

// File: tb/zcq_detector_tb.sv
module zcq_detector_tb;
  localparam int ERR_W = 7, TOL = 8, RUN_LEN = 4, CNT_W = 8, WIN = 64;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1, psave = 1'b0, xing_vld = 1'b0, bit_stb = 1'b0;
  logic signed [ERR_W-1:0] xing_err = '0;
  logic quality_o;
  logic [CNT_W-1:0] good_cnt_o, bad_cnt_o;

  int n_chk = 0, n_bad = 0;
  int m_run = 0, m_qual = 0, m_ag = 0, m_ab = 0, m_bits = 0, m_g = 0, m_b = 0;

  always #5 clk = ~clk;

  zcq_detector #(.ERR_W(ERR_W), .TOL(TOL), .RUN_LEN(RUN_LEN), .CNT_W(CNT_W),
                 .WIN(WIN), .TALLY_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .psave(psave), .xing_vld(xing_vld),
    .xing_err(xing_err), .bit_stb(bit_stb), .quality_o(quality_o),
    .good_cnt_o(good_cnt_o), .bad_cnt_o(bad_cnt_o));

  function automatic bit is_good(int e);  // R1
    int a;
    a = (e < 0) ? -e : e;
    return a <= TOL;
  endfunction

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit v, int e, bit b, bit p);
    bit g;
    int ng, nb;
    string qt, ct;
    xing_vld = v; xing_err = ERR_W'(e); bit_stb = b; psave = p;
    @(posedge clk);
    g = is_good(e);
    if (p) begin
      m_run = 0; m_qual = 0; qt = "R5";
    end else if (v) begin
      if (g) begin
        m_run = (m_run >= RUN_LEN) ? RUN_LEN : m_run + 1;
        m_qual = (m_run >= RUN_LEN); qt = "R3/R1";
      end else begin
        m_run = 0; m_qual = 0; qt = "R2/R1";
      end
    end else qt = "R4";
    if (p) begin
      m_ag = 0; m_ab = 0; m_bits = 0; m_g = 0; m_b = 0; ct = "R9";
    end else begin
      ng = sat(m_ag + ((v && g) ? 1 : 0));
      nb = sat(m_ab + ((v && !g) ? 1 : 0));
      if (b && m_bits == WIN - 1) begin
        m_g = ng; m_b = nb; m_ag = 0; m_ab = 0; m_bits = 0;
      end else begin
        m_ag = ng; m_ab = nb;
        if (b) m_bits++;
      end
      ct = (m_g == CMAX || m_b == CMAX) ? "R8" : "R7";
    end
    @(negedge clk);
    chk(qt, quality_o, m_qual);
    chk({ct, " good"}, good_cnt_o, m_g);
    chk({ct, " bad"}, bad_cnt_o, m_b);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R6 qual", quality_o, 0);
    chk("R6 good", good_cnt_o, 0);
    chk("R6 bad", bad_cnt_o, 0);

    // R3: three goods keep low, fourth raises
    step(1, 0, 0, 0); step(1, 8, 0, 0); step(1, -8, 0, 0);
    chk("R3 low after 3", quality_o, 0);
    step(1, 3, 0, 0);
    chk("R3 high after 4", quality_o, 1);
    // R4: idle holds
    repeat (5) step(0, 40, 1, 0);
    // R2 and R1 boundary: +9 is bad
    step(1, 9, 0, 0);
    chk("R2 drop on +9", quality_o, 0);
    repeat (4) step(1, -2, 0, 0);
    step(1, -9, 0, 0);
    chk("R1 -9 bad", quality_o, 0);
    repeat (4) step(1, 1, 0, 0);
    step(1, -64, 0, 0);
    chk("R1 -64 bad", quality_o, 0);
    // R5: psave mid-run, then full run needed
    repeat (2) step(1, 0, 0, 0);
    step(1, 0, 1, 1); step(1, 0, 1, 1);
    chk("R5 forced low", quality_o, 0);
    repeat (3) step(1, 0, 0, 0);
    chk("R5 still low after 3", quality_o, 0);
    step(1, 0, 0, 0);
    // R7: window close with coinciding crossing
    for (int i = 0; i < WIN; i++) step(i % 3 == 0, (i % 2) ? 20 : 2, 1, 0);
    // R8: dense crossings, sparse bit strobes
    for (int i = 0; i < WIN * 8; i++) step(1, 0, (i % 8) == 7, 0);
    chk("R8 saturated good", good_cnt_o, CMAX);
    for (int i = 0; i < WIN * 8; i++) step(1, 30, (i % 8) == 7, 0);
    chk("R8 saturated bad", bad_cnt_o, CMAX);
    step(0, 0, 0, 1);
    chk("R9 cleared", good_cnt_o + bad_cnt_o, 0);
    // random mix
    for (int i = 0; i < 15000; i++) begin
      int e;
      e = int'($urandom_range(0, 40)) - 20;
      if ($urandom_range(0, 9) == 0) e = ($urandom_range(0, 1) != 0) ? 63 : -64;
      step($urandom_range(0, 2) != 0, e, $urandom_range(0, 3) == 0,
           $urandom_range(0, 199) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule